// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs single register transactions against an Ethernet PHY over the two-wire management interface (clock line MDC plus bidirectional data line MDIO), using the clause 22 frame layout. A host asserts a one-cycle start strobe. With it the host presents a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block then shifts out the whole 64-bit frame one bit per MDC period. For reads it releases the data line and collects the 16 data bits that the PHY returns.

MDC is derived from the system clock by a counter. Each MDC level lasts `HALF_PERIOD` system clocks, and the parameter is chosen so that MDC stays at or below 2.5 MHz (10 at 50 MHz). The pad itself stays outside the block. The block offers output data, output enable and input data, and the integrator joins them into a tri-state pad. While a frame is in flight `busy` is high. At the end `done` pulses for one clock, and for a read `rd_data` holds the captured word.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 bits of value 1, all driven with the output enable high.
- R2: The preamble is followed by a start pattern 0 then 1, and then a two-bit opcode sent MSB first: 01 for a write (`rd_nwr`=0), 10 for a read (`rd_nwr`=1).
- R3: After the opcode come the 5-bit PHY address and then the 5-bit register address, each sent MSB first.
- R4: For a write, the turnaround bits 1 then 0 follow, then the 16 write-data bits MSB first, all driven by the master.
- R5: For a read, the output enable is low for both turnaround bits and all 16 data bits (frame bits 46 to 63). The data bits are sampled MSB first on the rising MDC edge, and `rd_data` shows the word from the cycle in which `done` is high. A write leaves `rd_data` unchanged.
- R6: `mdio_o` and `mdio_oe` change only while MDC is low. They are constant for the whole high phase of MDC.
- R7: Each MDC high and low phase lasts exactly `HALF_PERIOD` system clocks. A frame holds 64 MDC periods, and MDC is low whenever the block is idle.
- R8: A start strobe that arrives while `busy` is high is ignored. The frame in progress is unchanged and no second frame follows it.
- R9: `done` is high for exactly one clock, in the first clock after the last MDC falling edge. In that same clock `busy` is low and `mdio_oe` is low, and `mdio_oe` stays low while idle.
- R10: After reset `busy`, `done`, `mdc` and `mdio_oe` are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a frame |
| rd_nwr | input | 1 | 1 selects a read, 0 a write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data word for writes |
| rd_data | output | 16 | Word returned by the last read |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data driven toward the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Data read back from the pad |

## Verification
The bench sweeps every register address for both writes and reads, pairing each with a different PHY address and with data words derived from the address. This separates the address fields from each other and shows bit-order or field-swap faults. Edge data words (all zeros, all ones, and only the end bits set) show whether the first or last data bit is lost or shifted. A responding PHY model drives known words back and pulls the line low in the second turnaround bit. A read that fails to release the line, or that samples one bit off, therefore yields a wrong word. Some frames receive a second start strobe in mid-frame, to show that no field is corrupted and that no extra frame runs afterwards.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the management frame master.
// Assumes the clause 22 layout: 64 bit times per frame.
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_FIRST   = 46;   // first turnaround bit time
    localparam int DATA_FIRST = 48;   // first data bit time
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } mdio_opc_e;
endpackage

// File: rtl/mdio_clk_div.sv
// Bit-time strobe generator. While run is high it emits a one-clock tick
// every HALF_PERIOD clocks; the first tick comes HALF_PERIOD clocks after
// run rises. Assumes HALF_PERIOD >= 1.
module mdio_clk_div #(
    parameter int HALF_PERIOD = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks within one MDC level; hold at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);

    generate
        if (HALF_PERIOD > 1) begin : g_gap
            assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer. On start it loads the full 64-bit frame into a shift
// register and moves through the bit times, toggling MDC on each tick.
// Output data and enable change only at the falling MDC edge (or at load,
// with MDC low). Assumes tick comes from mdio_clk_div running on busy.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic              busy,
    output logic              mdc,
    output logic              mdo,
    output logic              oe,
    output logic              is_read,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              rise_evt,
    output logic              last_fall,
    output logic              done
);
    logic [FRAME_BITS-1:0] shreg_q;
    logic [FRAME_BITS-1:0] frame_w;
    logic [IDX_W-1:0]      next_idx;
    mdio_opc_e             opc_w;

    // Assemble the frame image that is loaded at start.
    always_comb begin
        opc_w   = rd_nwr ? OPC_READ : OPC_WRITE;
        frame_w = {32'hFFFF_FFFF, 2'b01, opc_w, phy_addr, reg_addr,
                   (rd_nwr ? 2'b00 : 2'b10),
                   (rd_nwr ? {DATA_W{1'b0}} : wr_data)};
    end

    assign next_idx  = bit_idx + 1'b1;
    assign rise_evt  = busy && tick && !mdc;
    assign last_fall = busy && tick && mdc && (bit_idx == IDX_W'(FRAME_BITS - 1));

    // Main sequence: load, MDC toggling, bit advance and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            mdc     <= 1'b0;
            mdo     <= 1'b0;
            oe      <= 1'b0;
            is_read <= 1'b0;
            bit_idx <= '0;
            shreg_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    mdc     <= 1'b0;
                    bit_idx <= '0;
                    shreg_q <= frame_w;
                    mdo     <= frame_w[FRAME_BITS-1];
                    oe      <= 1'b1;
                    is_read <= rd_nwr;
                end
            end else if (tick) begin
                if (!mdc) begin
                    mdc <= 1'b1;
                end else begin
                    mdc <= 1'b0;
                    if (last_fall) begin
                        busy <= 1'b0;
                        oe   <= 1'b0;
                        mdo  <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_idx <= next_idx;
                        shreg_q <= shreg_q << 1;
                        mdo     <= shreg_q[FRAME_BITS-2];
                        oe      <= !(is_read && (next_idx >= IDX_W'(TA_FIRST)));
                    end
                end
            end
        end
    end

    assert_pad_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdo) && $stable(oe)));
    assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_read && bit_idx >= IDX_W'(TA_FIRST)) |-> !oe);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !oe);
    assert_idle_mdc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_fall) |=> (busy && $stable(is_read)));
endmodule

// File: rtl/mdio_rx_capture.sv
// Read-data capture. It shifts in one bit per rising MDC edge during the
// data window and commits the word at the final falling edge of a read.
// Assumes rise_evt, in_window and commit come from the frame sequencer.
module mdio_rx_capture
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_evt,
    input  logic              in_window,
    input  logic              commit,
    input  logic              mdi,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sh_q;

    // Collect data bits MSB first on each rising MDC inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (rise_evt && in_window)
            sh_q <= {sh_q[DATA_W-2:0], mdi};
    end

    // Publish the word at the end of a read frame only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (commit)
            rd_data <= sh_q;
    end

    assert_hold_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit) |-> $stable(rd_data));
endmodule

// File: rtl/mdio_master.sv
// Top of the management frame master: divider, sequencer and capture.
// Assumes the integrator builds the tri-state pad from mdio_o/mdio_oe and
// returns the pad level on mdio_i. HALF_PERIOD sets clocks per MDC level.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_PERIOD = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd_nwr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        busy,
    output logic        done,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic             tick;
    logic             is_read;
    logic [IDX_W-1:0] bit_idx;
    logic             rise_evt;
    logic             last_fall;
    logic             in_window;

    mdio_clk_div #(.HALF_PERIOD(HALF_PERIOD)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_nwr   (rd_nwr),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .tick     (tick),
        .busy     (busy),
        .mdc      (mdc),
        .mdo      (mdio_o),
        .oe       (mdio_oe),
        .is_read  (is_read),
        .bit_idx  (bit_idx),
        .rise_evt (rise_evt),
        .last_fall(last_fall),
        .done     (done)
    );

    assign in_window = is_read && (bit_idx >= IDX_W'(DATA_FIRST));

    mdio_rx_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_evt (rise_evt),
        .in_window(in_window),
        .commit   (last_fall && is_read),
        .mdi      (mdio_i),
        .rd_data  (rd_data)
    );

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mdio_oe && !mdc));
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    mdio_master #(.HALF_PERIOD(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .done(done), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY responder and line monitor, all at the falling system clock.
    logic [15:0] resp = '0;
    logic        rec_v  [64];
    logic        rec_oe [64];
    int          rise_n = 0;
    int          hp_cnt = 0;
    int          hp_err = 0;
    int          stab_err = 0;
    logic        prev_mdc = 1'b0, prev_busy = 1'b0;
    logic        hold_o = 1'b0, hold_oe = 1'b0;

    always @(negedge clk) begin
        if (busy && !prev_busy) begin
            rise_n = 0;
            hp_cnt = 0;
        end else begin
            hp_cnt = hp_cnt + 1;
        end
        if (mdc != prev_mdc) begin
            if (hp_cnt != HALF) hp_err = hp_err + 1;
            hp_cnt = 0;
        end
        if (mdc && !prev_mdc) begin
            if (rise_n < 64) begin
                rec_v[rise_n]  = mdio_o;
                rec_oe[rise_n] = mdio_oe;
            end
            rise_n = rise_n + 1;
            hold_o  = mdio_o;
            hold_oe = mdio_oe;
        end else if (mdc && (mdio_o != hold_o || mdio_oe != hold_oe)) begin
            stab_err = stab_err + 1;
        end
        if (rise_n >= 48 && rise_n < 64) mdio_i = resp[63 - rise_n];
        else if (rise_n == 47)          mdio_i = 1'b0;
        else                            mdio_i = 1'b1;
        prev_mdc  = mdc;
        prev_busy = busy;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one frame, optionally with a stray start mid-frame, then check it.
    task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] rsp,
                             input bit stray);
        int n;
        logic [63:0] ev, av, ao, emask;
        logic [15:0] prev_rd;
        prev_rd = rd_data;
        resp = rsp;
        hp_err = 0;
        stab_err = 0;
        rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 2000) begin
            if (stray && n == 50) begin
                start = 1'b1; rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
            end
            if (stray && n == 52) start = 1'b0;
            if (stray && n == 200) start = 1'b1;
            if (stray && n == 201) start = 1'b0;
            @(negedge clk);
            n++;
        end
        ev = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra,
              (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
        av = '0; ao = '0;
        for (int i = 0; i < 64; i++) begin
            av[63-i] = rec_v[i];
            ao[63-i] = rec_oe[i];
        end
        emask = rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
        chk(n == 128*HALF + 1, "R7 frame length", 64'(n), 64'(128*HALF + 1));
        chk(rise_n == 64 && hp_err == 0, "R7 mdc phases", 64'(hp_err), 64'd0);
        chk(stab_err == 0, "R6 pad stable while mdc high", 64'(stab_err), 64'd0);
        chk(av[63:32] == 32'hFFFF_FFFF && ao[63:32] == 32'hFFFF_FFFF,
            "R1 preamble", {av[63:32], ao[63:32]}, 64'hFFFF_FFFF_FFFF_FFFF);
        chk(av[31:28] == ev[31:28], "R2 start and opcode", 64'(av[31:28]), 64'(ev[31:28]));
        chk(av[27:18] == ev[27:18], "R3 addresses", 64'(av[27:18]), 64'(ev[27:18]));
        if (!rd) begin
            chk(av[17:0] == ev[17:0], "R4 write turnaround and data",
                64'(av[17:0]), 64'(ev[17:0]));
            chk(ao == emask, "R4 write enable", ao, emask);
            chk(rd_data == prev_rd, "R5 write keeps rd_data", 64'(rd_data), 64'(prev_rd));
        end else begin
            chk(ao == emask, "R5 read release", ao, emask);
            chk(rd_data == rsp, "R5 read capture", 64'(rd_data), 64'(rsp));
        end
        chk(done && !busy && !mdio_oe, "R9 end state", {61'd0, done, busy, mdio_oe}, 64'h4);
        @(negedge clk);
        chk(!done && !mdio_oe, "R9 done single pulse", {62'd0, done, mdio_oe}, 64'h0);
        if (stray) begin
            repeat (3) @(negedge clk);
            chk(!busy, "R8 no queued frame", 64'(busy), 64'd0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mdc && !mdio_oe && rd_data == 16'h0, "R10 reset state",
            {43'd0, busy, done, mdc, mdio_oe, rd_data}, 64'h0);
        // Sweep all register addresses, writes and reads.
        for (int r = 0; r < 32; r++) begin
            run_frame(1'b0, 5'(r) ^ 5'h15, 5'(r), 16'hA5C3 ^ 16'(r * 16'h0101),
                      16'h0, (r % 8) == 3);
            run_frame(1'b1, 5'(31 - r), 5'(r), 16'h0,
                      16'h1234 + 16'(r * 16'h0F0F), (r % 8) == 5);
        end
        // Edge data words.
        run_frame(1'b0, 5'h00, 5'h1F, 16'h0000, 16'h0, 1'b0);
        run_frame(1'b0, 5'h1F, 5'h00, 16'hFFFF, 16'h0, 1'b0);
        run_frame(1'b0, 5'h10, 5'h01, 16'h8001, 16'h0, 1'b0);
        run_frame(1'b1, 5'h01, 5'h10, 16'h0, 16'h0000, 1'b0);
        run_frame(1'b1, 5'h1F, 5'h1F, 16'h0, 16'hFFFF, 1'b0);
        run_frame(1'b1, 5'h00, 5'h00, 16'h0, 16'h8001, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule